// File: doc/BRIEF.md
# Alarm Pattern Matrix Evaluator

This block watches six alarm lines that arrive with no timing relation to the system clock. Each line passes through a two-stage synchroniser. A filter then holds back any new level until it has stayed steady for a programmable number of microseconds. The six filtered levels form a 6-bit pattern index, and that index selects one bit from each of three 64-bit truth tables.

The first table sets the main alarm output. Because every pattern has its own bit, any OR of AND-combinations of the alarm lines can be programmed. The second table drives a red error indicator and the third drives a green status indicator. A yellow indicator lights while the alarm output is active. When the shutter input reads open, the yellow indicator blinks instead of staying on. The tables and the dwell value are plain inputs, held by whatever register logic sits beside this block.

Top module: `alarm_matrix_eval`

## Requirements
- R1: While `rst_n` is low at a clock edge, all four outputs are 0 after that edge, and the filtered pattern restarts at 0.
- R2: `alarm_o` equals `alarm_tbl_i[n]`, where n is the filtered pattern index {alm_i[5], alm_i[4], alm_i[3], alm_i[2], alm_i[1], alm_i[0]}. In that index, bit 5 is the sync alarm, bit 4 is the back alarm, and bits 3 to 0 are alarm lines 4 to 1.
- R3: `err_led_o` equals `err_tbl_i[n]` for the same index n.
- R4: `ok_led_o` equals `ok_tbl_i[n]` for the same index n.
- R5: With `dwell_us_i` = 0, a level change on an alarm line reaches the outputs within 4 clock cycles: 2 synchroniser stages, 1 filter stage and 1 output register.
- R6: With `dwell_us_i` = D > 0, a level that differs from the accepted one for fewer than (D-1)·CLK_PER_US cycles is discarded and has no effect on the outputs.
- R7: With `dwell_us_i` = D > 0, a level held for at least D·CLK_PER_US + 4 cycles is accepted, and the outputs follow it.
- R8: While `alarm_o` is 1 and the synchronised shutter is 0 (closed), `yellow_o` is 1.
- R9: While `alarm_o` is 1 and `shutter_i` is 1 (open), `yellow_o` toggles every BLINK_HALF_US microseconds.
- R10: `yellow_o` is 0 whenever `alarm_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alm_i | input | 6 | Asynchronous alarm lines; bit 5 is sync, bit 4 is back, bits 3..0 are alarms 4..1 |
| shutter_i | input | 1 | Asynchronous shutter state, 1 = open |
| dwell_us_i | input | 10 | Minimum steady time in microseconds, 0 to 1023 |
| alarm_tbl_i | input | 64 | Truth table for the alarm output, bit n for index n |
| err_tbl_i | input | 64 | Truth table for the red error indicator |
| ok_tbl_i | input | 64 | Truth table for the green status indicator |
| alarm_o | output | 1 | Main alarm output, registered |
| err_led_o | output | 1 | Red error indicator, registered |
| ok_led_o | output | 1 | Green status indicator, registered |
| yellow_o | output | 1 | Yellow indicator: steady with the alarm, blinking while the shutter is open |

## Verification
The assertions assume that the truth tables and the dwell value are quasi-static: they change only while the alarm lines are settled, so a one-cycle lookup relation holds. The stimulus changes tables and dwell only after the pattern has settled for several cycles, and changes the alarm lines only at falling clock edges. The glitch and hold widths are chosen well clear of the microsecond-tick quantisation, so each case has one clear expected result.

// File: rtl/alarm_pkg.sv
// Shared sizes for the alarm matrix evaluator.
// Assumes six alarm lines, so every truth table has 2**6 entries.
package alarm_pkg;
    localparam int unsigned NUM_ALM  = 6;
    localparam int unsigned TBL_SIZE = 1 << NUM_ALM;
    typedef logic [NUM_ALM-1:0] alm_pat_t;
endpackage

// File: rtl/alm_timebase.sv
// Makes a one-cycle microsecond tick and a square wave for blinking.
// Assumes CLK_PER_US >= 1 and BLINK_HALF_US >= 1.
module alm_timebase #(
    parameter int unsigned CLK_PER_US    = 100,
    parameter int unsigned BLINK_HALF_US = 250000
) (
    input  logic clk,
    input  logic rst_n,
    output logic us_tick_o,
    output logic blink_o
);
    localparam int unsigned PW = $clog2(CLK_PER_US + 1);
    localparam int unsigned BW = $clog2(BLINK_HALF_US + 1);

    logic [PW-1:0] pre_q;
    logic [BW-1:0] half_q;

    // Prescaler: divide the clock down to a microsecond tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q     <= '0;
            us_tick_o <= 1'b0;
        end else if (pre_q == PW'(CLK_PER_US - 1)) begin
            pre_q     <= '0;
            us_tick_o <= 1'b1;
        end else begin
            pre_q     <= pre_q + 1'b1;
            us_tick_o <= 1'b0;
        end
    end

    // Blink divider: toggle the square wave every BLINK_HALF_US ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q  <= '0;
            blink_o <= 1'b0;
        end else if (us_tick_o) begin
            if (half_q == BW'(BLINK_HALF_US - 1)) begin
                half_q  <= '0;
                blink_o <= ~blink_o;
            end else begin
                half_q <= half_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/alm_deglitch.sv
// Synchronises one asynchronous line and accepts a new level only after
// it has stayed steady for dwell_i microsecond ticks.
// Assumes dwell_i is quasi-static. A dwell of 0 passes the synchronised level through.
module alm_deglitch #(
    parameter int unsigned DWELL_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               async_i,
    input  logic               us_tick_i,
    input  logic [DWELL_W-1:0] dwell_i,
    output logic               sync_o,
    output logic               filt_o
);
    logic               meta_q;
    logic [DWELL_W-1:0] cnt_q;

    // Two-flop synchroniser.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_o <= 1'b0;
        end else begin
            meta_q <= async_i;
            sync_o <= meta_q;
        end
    end

    // Dwell filter: count ticks while the synchronised level differs from the accepted one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            filt_o <= 1'b0;
        end else if (sync_o == filt_o) begin
            cnt_q <= '0;
        end else if (dwell_i == '0) begin
            filt_o <= sync_o;
            cnt_q  <= '0;
        end else if (us_tick_i) begin
            if (cnt_q >= dwell_i - DWELL_W'(1)) begin
                filt_o <= sync_o;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/alm_lookup.sv
// Selects one bit from each truth table by the pattern index and registers
// the results, together with the yellow indicator.
// Assumes the tables are quasi-static and that the blink wave is a slow square wave.
module alm_lookup
    import alarm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  alm_pat_t            pat_i,
    input  logic                shut_open_i,
    input  logic                blink_i,
    input  logic [TBL_SIZE-1:0] alarm_tbl_i,
    input  logic [TBL_SIZE-1:0] err_tbl_i,
    input  logic [TBL_SIZE-1:0] ok_tbl_i,
    output logic                alarm_o,
    output logic                err_o,
    output logic                ok_o,
    output logic                yellow_o
);
    logic alarm_sel;

    // Table lookup for the alarm output.
    always_comb alarm_sel = alarm_tbl_i[pat_i];

    // Output registers for the three lookups and the yellow indicator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_o  <= 1'b0;
            err_o    <= 1'b0;
            ok_o     <= 1'b0;
            yellow_o <= 1'b0;
        end else begin
            alarm_o  <= alarm_sel;
            err_o    <= err_tbl_i[pat_i];
            ok_o     <= ok_tbl_i[pat_i];
            yellow_o <= alarm_sel & (shut_open_i ? blink_i : 1'b1);
        end
    end
endmodule

// File: rtl/alarm_matrix_eval.sv
// Top level: six filtered alarm lines index three 64-entry truth tables.
// Assumes CLK_PER_US clock cycles per microsecond. The shutter reads 1 when open.
module alarm_matrix_eval
    import alarm_pkg::*;
#(
    parameter int unsigned CLK_PER_US    = 100,
    parameter int unsigned BLINK_HALF_US = 250000,
    parameter int unsigned DWELL_W       = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_ALM-1:0]  alm_i,
    input  logic                shutter_i,
    input  logic [DWELL_W-1:0]  dwell_us_i,
    input  logic [TBL_SIZE-1:0] alarm_tbl_i,
    input  logic [TBL_SIZE-1:0] err_tbl_i,
    input  logic [TBL_SIZE-1:0] ok_tbl_i,
    output logic                alarm_o,
    output logic                err_led_o,
    output logic                ok_led_o,
    output logic                yellow_o
);
    logic     us_tick;
    logic     blink;
    logic     shut_meta_q;
    logic     shutter_s;
    alm_pat_t sync_pat;
    alm_pat_t filt_pat;

    alm_timebase #(
        .CLK_PER_US   (CLK_PER_US),
        .BLINK_HALF_US(BLINK_HALF_US)
    ) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .us_tick_o(us_tick),
        .blink_o  (blink)
    );

    for (genvar g = 0; g < NUM_ALM; g++) begin : g_line
        alm_deglitch #(.DWELL_W(DWELL_W)) u_dg (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_i  (alm_i[g]),
            .us_tick_i(us_tick),
            .dwell_i  (dwell_us_i),
            .sync_o   (sync_pat[g]),
            .filt_o   (filt_pat[g])
        );
    end

    // Shutter synchroniser; the shutter is not filtered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shut_meta_q <= 1'b0;
            shutter_s   <= 1'b0;
        end else begin
            shut_meta_q <= shutter_i;
            shutter_s   <= shut_meta_q;
        end
    end

    alm_lookup u_lk (
        .clk        (clk),
        .rst_n      (rst_n),
        .pat_i      (filt_pat),
        .shut_open_i(shutter_s),
        .blink_i    (blink),
        .alarm_tbl_i(alarm_tbl_i),
        .err_tbl_i  (err_tbl_i),
        .ok_tbl_i   (ok_tbl_i),
        .alarm_o    (alarm_o),
        .err_o      (err_led_o),
        .ok_o       (ok_led_o),
        .yellow_o   (yellow_o)
    );
endmodule

// File: rtl/alarm_matrix_chk.sv
// Assertion checker bound to alarm_matrix_eval. It observes the outputs and
// the internal pattern, tick and shutter nets.
module alarm_matrix_chk
    import alarm_pkg::*;
#(
    parameter int unsigned DWELL_W = 10
) (
    input logic                clk,
    input logic                rst_n,
    input alm_pat_t            sync_pat,
    input alm_pat_t            filt_pat,
    input logic                us_tick,
    input logic                shutter_s,
    input logic [DWELL_W-1:0]  dwell_us_i,
    input logic [TBL_SIZE-1:0] alarm_tbl_i,
    input logic [TBL_SIZE-1:0] err_tbl_i,
    input logic [TBL_SIZE-1:0] ok_tbl_i,
    input logic                alarm_o,
    input logic                err_led_o,
    input logic                ok_led_o,
    input logic                yellow_o
);
    // R1: reset clears the outputs and the filtered pattern.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!alarm_o && !err_led_o && !ok_led_o && !yellow_o && filt_pat == '0));

    // R2: the alarm output follows the table entry of the filtered pattern.
    assert_alarm_lookup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> alarm_o == $past(alarm_tbl_i[filt_pat]));

    // R3: the error indicator follows its table.
    assert_err_lookup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> err_led_o == $past(err_tbl_i[filt_pat]));

    // R4: the status indicator follows its table.
    assert_ok_lookup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ok_led_o == $past(ok_tbl_i[filt_pat]));

    // R5: with zero dwell the filter tracks the synchroniser one cycle later.
    assert_zero_dwell_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dwell_us_i) == '0) |-> filt_pat == $past(sync_pat));

    // R6: with a nonzero dwell the filtered pattern changes only on a tick.
    assert_hold_between_ticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dwell_us_i) != '0 && !$past(us_tick)) |-> $stable(filt_pat));

    // R8: steady yellow while the alarm is active and the shutter is closed.
    assert_steady_yellow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && alarm_o && !$past(shutter_s)) |-> yellow_o);

    // R10: no yellow without the alarm.
    assert_yellow_needs_alarm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        yellow_o |-> alarm_o);
endmodule

bind alarm_matrix_eval alarm_matrix_chk #(.DWELL_W(DWELL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_pat   (sync_pat),
    .filt_pat   (filt_pat),
    .us_tick    (us_tick),
    .shutter_s  (shutter_s),
    .dwell_us_i (dwell_us_i),
    .alarm_tbl_i(alarm_tbl_i),
    .err_tbl_i  (err_tbl_i),
    .ok_tbl_i   (ok_tbl_i),
    .alarm_o    (alarm_o),
    .err_led_o  (err_led_o),
    .ok_led_o   (ok_led_o),
    .yellow_o   (yellow_o)
);

// File: tb/tb_alarm_matrix_eval.sv
module tb_alarm_matrix_eval;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned CPU        = 4;
    localparam int unsigned HALF_US    = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  alm_i = '0;
    logic        shutter_i = 1'b0;
    logic [9:0]  dwell_us_i = '0;
    logic [63:0] alarm_tbl_i = '0;
    logic [63:0] err_tbl_i = '0;
    logic [63:0] ok_tbl_i = '0;
    logic        alarm_o, err_led_o, ok_led_o, yellow_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alarm_matrix_eval #(.CLK_PER_US(CPU), .BLINK_HALF_US(HALF_US)) dut (
        .clk(clk), .rst_n(rst_n), .alm_i(alm_i), .shutter_i(shutter_i),
        .dwell_us_i(dwell_us_i), .alarm_tbl_i(alarm_tbl_i), .err_tbl_i(err_tbl_i),
        .ok_tbl_i(ok_tbl_i), .alarm_o(alarm_o), .err_led_o(err_led_o),
        .ok_led_o(ok_led_o), .yellow_o(yellow_o)
    );

    // Expected table entry for a pattern: bit 5 = sync ... bit 0 = alarm 1.
    function automatic logic pick(input logic [63:0] tbl, input logic [5:0] pat);
        return tbl[pat];
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Apply a pattern with zero dwell and check all three lookups (R2, R3, R4, R5, R8, R10).
    task automatic apply_check(input logic [5:0] pat);
        alm_i = pat;
        cycles(4);
        check("R5_alarm", alarm_o, pick(alarm_tbl_i, pat));
        check("R2", alarm_o, pick(alarm_tbl_i, pat));
        check("R3", err_led_o, pick(err_tbl_i, pat));
        check("R4", ok_led_o, pick(ok_tbl_i, pat));
        check("R8_R10", yellow_o, pick(alarm_tbl_i, pat));
    endtask

    initial begin
        void'($urandom(32'h1b5e));
        // R1: reset state, with tables full of ones and alarms high
        alarm_tbl_i = '1; err_tbl_i = '1; ok_tbl_i = '1; alm_i = '1;
        cycles(3);
        check("R1_alarm", alarm_o, 1'b0);
        check("R1_err", err_led_o, 1'b0);
        check("R1_ok", ok_led_o, 1'b0);
        check("R1_yellow", yellow_o, 1'b0);
        alm_i = '0; alarm_tbl_i = '0; err_tbl_i = '0; ok_tbl_i = '0;
        rst_n = 1'b1;
        cycles(6);

        // Directed corners: index 0 and index 63 with one-hot tables
        alarm_tbl_i = 64'h1; err_tbl_i = 64'h8000_0000_0000_0000; ok_tbl_i = 64'h1;
        apply_check(6'd0);
        apply_check(6'd63);
        alarm_tbl_i = 64'h8000_0000_0000_0000;
        apply_check(6'd63);
        apply_check(6'd32);

        // Random tables and patterns with zero dwell
        for (int i = 0; i < 60; i++) begin
            if (i % 10 == 0) begin
                alarm_tbl_i = {$urandom, $urandom};
                err_tbl_i   = {$urandom, $urandom};
                ok_tbl_i    = {$urandom, $urandom};
                cycles(2);
            end
            apply_check(6'($urandom));
        end

        // R6 and R7: dwell of 5 us; only index 1 (alarm 1 = bit 0) raises the alarm
        alarm_tbl_i = 64'h2; err_tbl_i = '0; ok_tbl_i = 64'h2;
        alm_i = '0;
        cycles(6);
        dwell_us_i = 10'd5;
        cycles(2);
        alm_i = 6'b000001;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check("R6_glitch", alarm_o, 1'b0);
        end
        alm_i = '0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            check("R6_after", alarm_o, 1'b0);
        end
        alm_i = 6'b000001;
        cycles(12);
        check("R6_short_hold", alarm_o, 1'b0);
        cycles(CPU*5 + 4);
        check("R7_accept", alarm_o, 1'b1);
        check("R7_ok", ok_led_o, 1'b1);
        alm_i = '0;
        cycles(CPU*5 + 8);
        check("R7_release", alarm_o, 1'b0);

        // R8 and R9: yellow is steady with the shutter closed and blinks with it open
        dwell_us_i = '0;
        alm_i = 6'b000001;
        cycles(6);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check("R8_steady", yellow_o, 1'b1);
        end
        shutter_i = 1'b1;
        cycles(4);
        begin
            int ones = 0;
            int zeros = 0;
            for (int i = 0; i < 4*HALF_US*CPU; i++) begin
                @(negedge clk);
                if (yellow_o) ones++; else zeros++;
            end
            check("R9_on_seen", ones > 0, 1'b1);
            check("R9_off_seen", zeros > 0, 1'b1);
            check("R9_balance", (ones > zeros/2) && (zeros > ones/2), 1'b1);
        end
        check("R9_alarm_held", alarm_o, 1'b1);
        // R10: alarm off, shutter open: yellow stays off
        alm_i = '0;
        cycles(4);
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            check("R10_off", yellow_o, 1'b0);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule